// File: doc/BRIEF.md
# SD Host Masked Interrupt Status Unit

This block keeps the event and interrupt bookkeeping of an SD/MMC host controller. Single-cycle event pulses from the command, data and card-detect engines land in sticky status bits, spread over two status bytes. Software clears these bits by writing ones to them. Each sticky event that can raise an interrupt has its own enable bit in one of two mask bytes. A single level interrupt line is the OR of all enabled pending events. That OR passes only while a global enable is set.

Alongside the sticky bits, the status bytes also show live levels: the write-protect switch, both card-detect sources and the two busy flags of the transfer engines. The upper byte of the 16-bit block-length register sits here too. It holds the global interrupt enable, the card-detect source select and polarity, and the abort-on-CRC-error enable. From these settings the unit derives a card-present indication.

Access is through a plain byte register port. Writes take effect on the clock edge and reads are combinational.

Top module: `sdh_irq_status`

## Requirements
- R1: A pulse on `evt_sts1_i[k]` sets status byte 1 bit k (0 SDIO interrupt, 1 command/response done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error) on the next edge. The bit stays set after the pulse ends. A pulse on `evt_sts0_i[j]` sets status byte 0 bit j+4 (4 multi-block done, 5 block done, 6 card detect, 7 device inserted) in the same way.
- R2: A write to a status byte (address 0 or 1) clears exactly the sticky bits written as 1. Writing 0xFF clears every sticky bit of that byte.
- R3: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: `irq_o` is high exactly when the global enable (address 6 bit 7, block-length bit 15) is set and some status bit is set whose mask bit is also set. Mask byte 0 (address 4) implements bits 7..4. Mask byte 1 (address 5) implements bits 7..1. Mask bits that are not implemented read 0, so the SDIO bit never raises the interrupt.
- R5: Status byte 0 bit 1 shows `wp_i`, bit 2 shows `dat3_cd_i` and bit 3 shows `gpi_cd_i`, all as live levels. Bit 0 reads 0. Writes to the byte leave these levels unchanged.
- R6: `card_present_o` follows the selected source. Address 6 bit 6 selects DAT3 and has priority. Address 6 bit 5 selects the GPI pin. With neither bit set the output is 0. When address 6 bit 4 is 1, the present level equals the source level. When it is 0, the present level is the inverse of the source level.
- R7: Status byte 2 (address 2) shows `cmd_busy_i` at bit 4 and `dat_busy_i` at bit 5. Bit 7 is a read/write bit that drives `clk_freeze_en_o`. The other bits read 0.
- R8: After reset every status, mask and configuration bit is 0, and `irq_o`, `crc_abort_en_o` and `clk_freeze_en_o` are low.
- R9: Address 6 keeps bits 7..3 and drives `crc_abort_en_o` from bit 3. Its bits 2..0 read 0.
- R10: Status byte 3 (address 3) and address 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write byte address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read byte address |
| rd_data_o | output | 8 | Register read data (combinational) |
| evt_sts0_i | input | 4 | Event pulses for status byte 0 bits 7..4 |
| evt_sts1_i | input | 8 | Event pulses for status byte 1 bits 7..0 |
| wp_i | input | 1 | Write-protect switch level |
| dat3_cd_i | input | 1 | DAT3 card-detect level |
| gpi_cd_i | input | 1 | GPI card-detect pin level |
| cmd_busy_i | input | 1 | Command/response engine busy |
| dat_busy_i | input | 1 | Data response busy |
| irq_o | output | 1 | Level interrupt |
| card_present_o | output | 1 | Card-present indication |
| crc_abort_en_o | output | 1 | Abort-on-CRC-error enable |
| clk_freeze_en_o | output | 1 | Automatic clock freezing enable |

## Verification
A table of event and mask pairs exercises the interrupt OR. One pair hits a matching enabled bit. One pair has an event next to an enabled bit. One sets only the unmaskable SDIO bit. One sets all events with no mask. Together these show whether the mask is applied per bit or per byte. Directed tests then cover several cases: partial clear against full clear, an event colliding with a clear, writes against the live level bits, the enable gate, and every source and polarity setting of card detect, including the case where both sources are selected.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STS0 = 3'd0,
    A_STS1 = 3'd1,
    A_STS2 = 3'd2,
    A_STS3 = 3'd3,
    A_MSK0 = 3'd4,
    A_MSK1 = 3'd5,
    A_CFG  = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  // status byte 0 live-level positions
  localparam int S0_WP      = 1;
  localparam int S0_CD_DAT3 = 2;
  localparam int S0_CD_GPI  = 3;
  localparam int S0_EVT_LSB = 4;
  // status byte 2 positions
  localparam int S2_CMD_BUSY = 4;
  localparam int S2_DAT_BUSY = 5;
  // configuration byte (block-length bits 15..8)
  localparam int CFG_CRC_ABORT = 3;
  localparam int CFG_POL_HIGH  = 4;
  localparam int CFG_SEL_GPI   = 5;
  localparam int CFG_SEL_DAT3  = 6;
  localparam int CFG_GIE       = 7;

  localparam logic [REG_W-1:0] STICKY0_BITS = 8'hF0;
  localparam logic [REG_W-1:0] STICKY1_BITS = 8'hFF;
  localparam logic [REG_W-1:0] MASK0_BITS   = 8'hF0;
  localparam logic [REG_W-1:0] MASK1_BITS   = 8'hFE;
  localparam logic [REG_W-1:0] CFG_BITS     = 8'hF8;
  localparam logic [REG_W-1:0] CTL2_BITS    = 8'h80;

  // next value of a write-one-to-clear byte; a set wins over a clear
  function automatic logic [REG_W-1:0] w1c_next(
      input logic [REG_W-1:0] cur,
      input logic [REG_W-1:0] clr,
      input logic [REG_W-1:0] set,
      input logic [REG_W-1:0] keep);
    return ((cur & ~clr) | set) & keep;
  endfunction

  function automatic logic any_pending(
      input logic [REG_W-1:0] sts,
      input logic [REG_W-1:0] msk);
    return |(sts & msk);
  endfunction

  function automatic logic cd_present(
      input logic sel_a, input logic sel_b, input logic pol_high,
      input logic lvl_a, input logic lvl_b);
    logic raw;
    if (sel_a)      raw = lvl_a;
    else if (sel_b) raw = lvl_b;
    else            return 1'b0;
    return pol_high ? raw : ~raw;
  endfunction
endpackage

// File: rtl/sdh_sticky_byte.sv
module sdh_sticky_byte
  import sdh_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= w1c_next(q_r, clr_i, set_i, KEEP);
  end

  assign q_o = q_r;
endmodule

// File: rtl/sdh_rw_byte.sv
module sdh_rw_byte #(
  parameter int W = 8,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (we_i) q_r <= wd_i & WMASK;
  end

  assign q_o = q_r;
endmodule

// File: rtl/sdh_card_detect.sv
module sdh_card_detect
  import sdh_irq_pkg::*;
#(
  parameter bit DAT3_FIRST = 1'b1
) (
  input  logic sel_dat3_i,
  input  logic sel_gpi_i,
  input  logic pol_high_i,
  input  logic dat3_i,
  input  logic gpi_i,
  output logic present_o
);
  generate
    if (DAT3_FIRST) begin : g_dat3_first
      assign present_o = cd_present(sel_dat3_i, sel_gpi_i, pol_high_i, dat3_i, gpi_i);
    end else begin : g_gpi_first
      assign present_o = cd_present(sel_gpi_i, sel_dat3_i, pol_high_i, gpi_i, dat3_i);
    end
  endgenerate
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [3:0]        evt_sts0_i,
  input  logic [REG_W-1:0]  evt_sts1_i,
  input  logic              wp_i,
  input  logic              dat3_cd_i,
  input  logic              gpi_cd_i,
  input  logic              cmd_busy_i,
  input  logic              dat_busy_i,
  output logic              irq_o,
  output logic              card_present_o,
  output logic              crc_abort_en_o,
  output logic              clk_freeze_en_o
);
  localparam int NREG = 1 << ADDR_W;

  // decoded write strobes, one per byte address
  logic [NREG-1:0] wr_hit;
  always_comb begin
    wr_hit = '0;
    if (wr_en_i) wr_hit[wr_addr_i] = 1'b1;
  end

  // named internal events
  logic [REG_W-1:0] clr0, clr1, set0, set1;
  assign clr0 = wr_hit[A_STS0] ? wr_data_i : '0;
  assign clr1 = wr_hit[A_STS1] ? wr_data_i : '0;
  assign set0 = {evt_sts0_i, {S0_EVT_LSB{1'b0}}};
  assign set1 = evt_sts1_i;

  logic [REG_W-1:0] sts0_q, sts1_q, msk0_q, msk1_q, cfg_q, ctl2_q;

  sdh_sticky_byte #(.W(REG_W), .KEEP(STICKY0_BITS)) u_sts0 (
    .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_i(clr0), .q_o(sts0_q));
  sdh_sticky_byte #(.W(REG_W), .KEEP(STICKY1_BITS)) u_sts1 (
    .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_i(clr1), .q_o(sts1_q));

  sdh_rw_byte #(.W(REG_W), .WMASK(MASK0_BITS)) u_msk0 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[A_MSK0]), .wd_i(wr_data_i), .q_o(msk0_q));
  sdh_rw_byte #(.W(REG_W), .WMASK(MASK1_BITS)) u_msk1 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[A_MSK1]), .wd_i(wr_data_i), .q_o(msk1_q));
  sdh_rw_byte #(.W(REG_W), .WMASK(CFG_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[A_CFG]), .wd_i(wr_data_i), .q_o(cfg_q));
  sdh_rw_byte #(.W(REG_W), .WMASK(CTL2_BITS)) u_ctl2 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[A_STS2]), .wd_i(wr_data_i), .q_o(ctl2_q));

  // read views with live levels merged in
  logic [REG_W-1:0] lvl0, lvl2, sts0_rd, sts2_rd;
  always_comb begin
    lvl0 = '0;
    lvl0[S0_WP]      = wp_i;
    lvl0[S0_CD_DAT3] = dat3_cd_i;
    lvl0[S0_CD_GPI]  = gpi_cd_i;
    lvl2 = '0;
    lvl2[S2_CMD_BUSY] = cmd_busy_i;
    lvl2[S2_DAT_BUSY] = dat_busy_i;
  end
  assign sts0_rd = sts0_q | lvl0;
  assign sts2_rd = ctl2_q | lvl2;

  always_comb begin
    unique case (rd_addr_i)
      A_STS0:  rd_data_o = sts0_rd;
      A_STS1:  rd_data_o = sts1_q;
      A_STS2:  rd_data_o = sts2_rd;
      A_MSK0:  rd_data_o = msk0_q;
      A_MSK1:  rd_data_o = msk1_q;
      A_CFG:   rd_data_o = cfg_q;
      default: rd_data_o = '0;
    endcase
  end

  // interrupt combine
  logic pend0, pend1, gie;
  assign pend0 = any_pending(sts0_q, msk0_q);
  assign pend1 = any_pending(sts1_q, msk1_q);
  assign gie   = cfg_q[CFG_GIE];
  assign irq_o = gie & (pend0 | pend1);

  sdh_card_detect #(.DAT3_FIRST(1'b1)) u_cd (
    .sel_dat3_i(cfg_q[CFG_SEL_DAT3]),
    .sel_gpi_i (cfg_q[CFG_SEL_GPI]),
    .pol_high_i(cfg_q[CFG_POL_HIGH]),
    .dat3_i    (dat3_cd_i),
    .gpi_i     (gpi_cd_i),
    .present_o (card_present_o));

  assign crc_abort_en_o  = cfg_q[CFG_CRC_ABORT];
  assign clk_freeze_en_o = ctl2_q[REG_W-1];
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk
  import sdh_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [3:0]        evt_sts0_i,
  input logic [REG_W-1:0]  evt_sts1_i,
  input logic [REG_W-1:0]  sts0_q,
  input logic [REG_W-1:0]  sts1_q,
  input logic [REG_W-1:0]  msk0_q,
  input logic [REG_W-1:0]  msk1_q,
  input logic              gie,
  input logic              sel_dat3,
  input logic              sel_gpi,
  input logic              irq_o,
  input logic              card_present_o,
  input logic              clk_freeze_en_o
);
  assert_evt1_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sts1_i != '0) |=> ((sts1_q & $past(evt_sts1_i)) == $past(evt_sts1_i)));

  // set wins over a clear in the same cycle
  assert_evt0_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sts0_i != '0) |=> ((sts0_q[7:4] & $past(evt_sts0_i)) == $past(evt_sts0_i)));

  assert_w1c_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_STS1 && evt_sts1_i == '0)
      |=> (sts1_q == ($past(sts1_q) & ~$past(wr_data_i))));

  assert_no_clear_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_addr_i == A_STS1) |=> ((sts1_q & $past(sts1_q)) == $past(sts1_q)));

  assert_gie_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_o);

  assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((sts0_q & msk0_q) == '0) && ((sts1_q & msk1_q) == '0)) |-> !irq_o);

  assert_cd_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_dat3 && !sel_gpi) |-> !card_present_o);

  assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_addr_i == A_STS2) |=> $stable(clk_freeze_en_o));
endmodule

bind sdh_irq_status sdh_irq_status_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .evt_sts0_i     (evt_sts0_i),
  .evt_sts1_i     (evt_sts1_i),
  .sts0_q         (sts0_q),
  .sts1_q         (sts1_q),
  .msk0_q         (msk0_q),
  .msk1_q         (msk1_q),
  .gie            (gie),
  .sel_dat3       (cfg_q[6]),
  .sel_gpi        (cfg_q[5]),
  .irq_o          (irq_o),
  .card_present_o (card_present_o),
  .clk_freeze_en_o(clk_freeze_en_o)
);

// File: tb/sdh_irq_status_tb.sv
module sdh_irq_status_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG_CYC = 100000;
  localparam int NVEC = 6;
  // each entry: {status-1 event pattern, mask-1 write value}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h02, 8'h02},
    {8'h04, 8'h02},
    {8'h01, 8'hFE},
    {8'h80, 8'hFF},
    {8'h30, 8'h0F},
    {8'hFF, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] evt0 = '0;
  logic [7:0] evt1 = '0;
  logic wp = 1'b0, dat3 = 1'b0, gpi = 1'b0, cbusy = 1'b0, dbusy = 1'b0;
  logic irq, cpres, crcab, frz;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] v;

  always #(CLK_P/2) clk = ~clk;

  sdh_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_sts0_i(evt0), .evt_sts1_i(evt1), .wp_i(wp), .dat3_cd_i(dat3),
    .gpi_cd_i(gpi), .cmd_busy_i(cbusy), .dat_busy_i(dbusy),
    .irq_o(irq), .card_present_o(cpres), .crc_abort_en_o(crcab),
    .clk_freeze_en_o(frz));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] e0, input logic [7:0] e1);
    @(negedge clk);
    evt0 = e0; evt1 = e1;
    @(negedge clk);
    evt0 = '0; evt1 = '0;
  endtask

  function automatic logic exp_irq1(input logic [7:0] e, input logic [7:0] m);
    logic [7:0] eff_m;
    eff_m = m;
    eff_m[0] = 1'b0; // SDIO bit has no mask
    return (e & eff_m) != 8'h00;
  endfunction

  initial begin
    #(CLK_P * WDOG_CYC);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R8 reset reg", v, 8'h00);
    end
    check("R8 irq", {7'b0, irq}, 8'h00);
    check("R8 crc abort", {7'b0, crcab}, 8'h00);
    check("R8 clk freeze", {7'b0, frz}, 8'h00);

    // vector table: R1/R4 on status byte 1
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd1, 8'hFF);
      wr(3'd5, VEC[i][7:0]);
      wr(3'd6, 8'h80);
      pulse(4'h0, VEC[i][15:8]);
      #1;
      check("R4 irq vector", {7'b0, irq}, {7'b0, exp_irq1(VEC[i][15:8], VEC[i][7:0])});
      rd(3'd1, v);
      check("R1 sticky vector", v, VEC[i][15:8]);
    end
    rd(3'd5, v);
    check("R4 mask1 bit0 unimplemented", v, 8'h00);

    // R2 partial and full clear
    wr(3'd1, 8'hFF);
    pulse(4'h0, 8'hA5);
    wr(3'd1, 8'h05);
    rd(3'd1, v);
    check("R2 partial clear", v, 8'hA0);
    wr(3'd1, 8'hFF);
    rd(3'd1, v);
    check("R2 full clear", v, 8'h00);

    // R3 collision: event and clear on bit 3 together
    pulse(4'h0, 8'h08);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h08; evt1 = 8'h08;
    @(negedge clk);
    wr_en = 1'b0; evt1 = '0;
    rd(3'd1, v);
    check("R3 set beats clear", v, 8'h08);

    // R1/R4 on status byte 0 with global enable gate
    wr(3'd1, 8'hFF);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'hFF);
    rd(3'd4, v);
    check("R4 mask0 width", v, 8'hF0);
    pulse(4'b0100, 8'h00);
    rd(3'd0, v);
    check("R1 status0 bit6", v, 8'h40);
    check("R4 irq from byte0", {7'b0, irq}, 8'h01);
    wr(3'd6, 8'h00);
    #1;
    check("R4 global enable off", {7'b0, irq}, 8'h00);

    // R5 live levels, writes do not clear them
    @(negedge clk);
    wp = 1'b1; gpi = 1'b1; dat3 = 1'b0;
    rd(3'd0, v);
    check("R5 levels plus sticky", v, 8'h4A);
    wr(3'd0, 8'hFF);
    rd(3'd0, v);
    check("R5 levels survive clear", v, 8'h0A);

    // R6 card detect source and polarity
    dat3 = 1'b1; gpi = 1'b0;
    wr(3'd6, 8'h50);
    check("R6 dat3 active-high", {7'b0, cpres}, 8'h01);
    wr(3'd6, 8'h40);
    check("R6 dat3 active-low", {7'b0, cpres}, 8'h00);
    wr(3'd6, 8'h20);
    check("R6 gpi active-low level0", {7'b0, cpres}, 8'h01);
    @(negedge clk); gpi = 1'b1; #1;
    check("R6 gpi active-low level1", {7'b0, cpres}, 8'h00);
    @(negedge clk); gpi = 1'b0;
    wr(3'd6, 8'h70);
    check("R6 dat3 priority", {7'b0, cpres}, 8'h01);
    wr(3'd6, 8'h10);
    check("R6 no source", {7'b0, cpres}, 8'h00);

    // R7 busy levels and freeze control
    @(negedge clk); cbusy = 1'b1;
    rd(3'd2, v);
    check("R7 cmd busy", v, 8'h10);
    wr(3'd2, 8'hFF);
    @(negedge clk); dbusy = 1'b1;
    rd(3'd2, v);
    check("R7 freeze bit and busy", v, 8'hB0);
    check("R7 freeze output", {7'b0, frz}, 8'h01);

    // R9 configuration width and CRC abort
    wr(3'd6, 8'h0F);
    rd(3'd6, v);
    check("R9 cfg low bits", v, 8'h08);
    check("R9 crc abort out", {7'b0, crcab}, 8'h01);

    // R10 reserved addresses
    wr(3'd3, 8'hFF);
    rd(3'd3, v);
    check("R10 status3", v, 8'h00);
    wr(3'd7, 8'hFF);
    rd(3'd7, v);
    check("R10 addr7", v, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule